// File: doc/BRIEF.md
# Disk Sector Address Translator

This block converts the address held in a disk controller's task-file registers into a 28-bit linear block number. It takes the sector number, the two cylinder bytes and the device/head byte, plus the drive geometry in force: cylinder count, head count and sectors per track. The command sequencer pulses `start_i`. Some cycles later the block pulses `done_o`, presents the linear address, and raises `bad_addr_o` when the address lies outside the geometry. The sequencer uses that flag to abort the command.

Bit 6 of the device/head byte picks the addressing form. When it is set, the four registers are joined directly into the linear number. When it is clear, the registers are read as cylinder, head and sector, checked against the geometry, and mapped with two shift-add multiplies that run one bit per cycle. All inputs are captured on the start cycle. The result registers hold their value until the next operation completes.

Top module: `sector_addr_xlate`

## Requirements
- R1: After reset `done_o`, `bad_addr_o` and `lba_o` are all 0.
- R2: With device/head bit 6 set, `lba_o` = {device/head[3:0], cylinder-high, cylinder-low, sector}. `bad_addr_o` is 0 and no range check is made, even for sector 0 or geometry the address exceeds.
- R3: With bit 6 clear, cylinder = {cylinder-high, cylinder-low} and head = device/head[3:0], so bits 7, 5 and 4 are ignored. A valid address gives `lba_o` = (cylinder × H + head) × S + sector − 1, where H = `geo_heads_i` and S = `geo_spt_i` are plain counts.
- R4: In cylinder/head/sector form, a cylinder greater than or equal to `geo_cyls_i` is invalid; cylinder `geo_cyls_i` − 1 is valid.
- R5: In cylinder/head/sector form, a head greater than or equal to `geo_heads_i` is invalid.
- R6: Sector 0 is invalid in cylinder/head/sector form, because sectors count from one.
- R7: A sector above `geo_spt_i` is invalid, and a sector equal to it is valid. Sectors per track go up to 256 and heads up to 16.
- R8: An invalid address gives `bad_addr_o` = 1 and `lba_o` = 0.
- R9: Each accepted start yields exactly one single-cycle `done_o`. It comes 1 cycle after the sampling edge for linear or rejected addresses, and HEAD_CNT_W + SPT_W + 3 cycles after it for valid cylinder/head/sector addresses. A start raised while an operation is running is ignored.
- R10: `lba_o` and `bad_addr_o` change only on the edge that raises `done_o`, and hold between completions.
- R11: Address and geometry inputs are sampled on the start cycle. Changing them later does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a translation (taken only when idle) |
| sec_num_i | input | 8 | Sector number register |
| cyl_lo_i | input | 8 | Cylinder low byte |
| cyl_hi_i | input | 8 | Cylinder high byte |
| dev_head_i | input | 8 | Device/head register; bit 6 selects linear form, bits 3:0 head |
| geo_cyls_i | input | CYL_W | Cylinder count of current geometry |
| geo_heads_i | input | HEAD_CNT_W | Head count (1..16) |
| geo_spt_i | input | SPT_W | Sectors per track (1..256) |
| done_o | output | 1 | One-cycle completion pulse |
| lba_o | output | 28 | Linear block address |
| bad_addr_o | output | 1 | Address outside geometry |

## Verification
The bench uses the default parameters: a 16-bit cylinder count, 5-bit head count and 9-bit sectors-per-track. These widths cover the 16-head and 256-sector limits and the largest cylinder, so the largest product, which needs all 28 output bits, can be reached. The default widths also fix the cylinder/head/sector latency at 17 cycles, and the bench checks that value exactly. Random geometries bias each field to just below, at and just above its limit.

// File: rtl/sax_pkg.sv
package sax_pkg;

    localparam int TF_W       = 8;
    localparam int HEAD_FLD_W = 4;
    localparam int MODE_BIT   = 6;
    localparam int CYL_FLD_W  = 2 * TF_W;
    localparam int LINEAR_W   = HEAD_FLD_W + 3 * TF_W;

    typedef struct packed {
        logic                  linear;
        logic [HEAD_FLD_W-1:0] head;
        logic [CYL_FLD_W-1:0]  cyl;
        logic [TF_W-1:0]       sec;
    } tf_addr_t;

    typedef struct packed {
        logic cyl_over;
        logic head_over;
        logic sec_zero;
        logic sec_over;
    } range_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_MUL_HEAD,
        ST_MUL_SPT
    } xlate_state_e;

    function automatic tf_addr_t decode_tf(
        input logic [TF_W-1:0] sec,
        input logic [TF_W-1:0] lo,
        input logic [TF_W-1:0] hi,
        input logic [TF_W-1:0] dh
    );
        tf_addr_t a;
        a.linear = dh[MODE_BIT];
        a.head   = dh[HEAD_FLD_W-1:0];
        a.cyl    = {hi, lo};
        a.sec    = sec;
        return a;
    endfunction

    function automatic logic [LINEAR_W-1:0] direct_linear(input tf_addr_t a);
        return {a.head, a.cyl, a.sec};
    endfunction

    function automatic logic any_flag(input range_flags_t f);
        return f.cyl_over | f.head_over | f.sec_zero | f.sec_over;
    endfunction

endpackage

// File: rtl/sax_range_check.sv
module sax_range_check
    import sax_pkg::*;
#(
    parameter int CYL_W      = 16,
    parameter int HEAD_CNT_W = 5,
    parameter int SPT_W      = 9
) (
    input  tf_addr_t              addr,
    input  logic [CYL_W-1:0]      geo_cyls,
    input  logic [HEAD_CNT_W-1:0] geo_heads,
    input  logic [SPT_W-1:0]      geo_spt,
    output range_flags_t          flags
);

    localparam int C_CMP_W = (CYL_W > CYL_FLD_W) ? CYL_W : CYL_FLD_W;
    localparam int H_CMP_W = (HEAD_CNT_W > HEAD_FLD_W) ? HEAD_CNT_W : HEAD_FLD_W;
    localparam int S_CMP_W = (SPT_W > TF_W) ? SPT_W : TF_W;

    logic [C_CMP_W-1:0] cyl_a, cyl_g;
    logic [H_CMP_W-1:0] head_a, head_g;
    logic [S_CMP_W-1:0] sec_a, sec_g;

    always_comb begin
        cyl_a  = C_CMP_W'(addr.cyl);
        cyl_g  = C_CMP_W'(geo_cyls);
        head_a = H_CMP_W'(addr.head);
        head_g = H_CMP_W'(geo_heads);
        sec_a  = S_CMP_W'(addr.sec);
        sec_g  = S_CMP_W'(geo_spt);

        flags.cyl_over  = (cyl_a >= cyl_g);
        flags.head_over = (head_a >= head_g);
        flags.sec_zero  = (addr.sec == '0);
        flags.sec_over  = (sec_a > sec_g);
    end

endmodule

// File: rtl/sax_shift_mul.sv
module sax_shift_mul #(
    parameter int A_W = 16,
    parameter int B_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    output logic [A_W+B_W-1:0] prod,
    output logic               fin
);

    localparam int P_W   = A_W + B_W;
    localparam int CNT_W = $clog2(B_W + 1);

    logic [P_W-1:0]   acc;
    logic [P_W-1:0]   addend;
    logic [B_W-1:0]   mplr;
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            addend <= '0;
            mplr   <= '0;
            left   <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                acc    <= '0;
                addend <= P_W'(a);
                mplr   <= b;
                left   <= CNT_W'(B_W);
            end else if (left != '0) begin
                if (mplr[0]) begin
                    acc <= acc + addend;
                end
                addend <= addend << 1;
                mplr   <= mplr >> 1;
                left   <= left - 1'b1;
                if (left == CNT_W'(1)) begin
                    fin <= 1'b1;
                end
            end
        end
    end

    assign prod = acc;

endmodule

// File: rtl/sector_addr_xlate.sv
module sector_addr_xlate
    import sax_pkg::*;
#(
    parameter int CYL_W      = 16,
    parameter int HEAD_CNT_W = 5,
    parameter int SPT_W      = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [7:0]            sec_num_i,
    input  logic [7:0]            cyl_lo_i,
    input  logic [7:0]            cyl_hi_i,
    input  logic [7:0]            dev_head_i,
    input  logic [CYL_W-1:0]      geo_cyls_i,
    input  logic [HEAD_CNT_W-1:0] geo_heads_i,
    input  logic [SPT_W-1:0]      geo_spt_i,
    output logic                  done_o,
    output logic [27:0]           lba_o,
    output logic                  bad_addr_o
);

    localparam int LBA_W = LINEAR_W;
    localparam int P1_W  = CYL_W + HEAD_CNT_W;
    localparam int P2_W  = P1_W + SPT_W;

    xlate_state_e          st;
    tf_addr_t              q_addr;
    logic [CYL_W-1:0]      q_cyls;
    logic [HEAD_CNT_W-1:0] q_heads;
    logic [SPT_W-1:0]      q_spt;
    logic [LBA_W-1:0]      lba_q;
    logic                  bad_q;
    logic                  done_q;

    range_flags_t          flags;
    logic                  reject;
    logic                  m1_load, m1_fin;
    logic                  m2_load, m2_fin;
    logic [P1_W-1:0]       m1_prod;
    logic [P1_W-1:0]       track_idx;
    logic [P2_W-1:0]       m2_prod;
    logic [P2_W:0]         chs_sum;
    logic [LBA_W-1:0]      chs_lba;

    sax_range_check #(
        .CYL_W     (CYL_W),
        .HEAD_CNT_W(HEAD_CNT_W),
        .SPT_W     (SPT_W)
    ) u_range (
        .addr     (q_addr),
        .geo_cyls (q_cyls),
        .geo_heads(q_heads),
        .geo_spt  (q_spt),
        .flags    (flags)
    );

    assign reject  = any_flag(flags);
    assign m1_load = (st == ST_EVAL) && !q_addr.linear && !reject;
    assign m2_load = (st == ST_MUL_HEAD) && m1_fin;

    sax_shift_mul #(
        .A_W(CYL_W),
        .B_W(HEAD_CNT_W)
    ) u_mul_head (
        .clk (clk),
        .rst (rst),
        .load(m1_load),
        .a   (CYL_W'(q_addr.cyl)),
        .b   (q_heads),
        .prod(m1_prod),
        .fin (m1_fin)
    );

    assign track_idx = m1_prod + P1_W'(q_addr.head);

    sax_shift_mul #(
        .A_W(P1_W),
        .B_W(SPT_W)
    ) u_mul_spt (
        .clk (clk),
        .rst (rst),
        .load(m2_load),
        .a   (track_idx),
        .b   (q_spt),
        .prod(m2_prod),
        .fin (m2_fin)
    );

    always_comb begin
        chs_sum = {1'b0, m2_prod} + (P2_W+1)'(q_addr.sec) - (P2_W+1)'(1);
        chs_lba = LBA_W'(chs_sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            q_addr  <= '0;
            q_cyls  <= '0;
            q_heads <= '0;
            q_spt   <= '0;
            lba_q   <= '0;
            bad_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        q_addr  <= decode_tf(sec_num_i, cyl_lo_i, cyl_hi_i, dev_head_i);
                        q_cyls  <= geo_cyls_i;
                        q_heads <= geo_heads_i;
                        q_spt   <= geo_spt_i;
                        st      <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (q_addr.linear) begin
                        lba_q  <= direct_linear(q_addr);
                        bad_q  <= 1'b0;
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else if (reject) begin
                        lba_q  <= '0;
                        bad_q  <= 1'b1;
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        st <= ST_MUL_HEAD;
                    end
                end
                ST_MUL_HEAD: begin
                    if (m1_fin) begin
                        st <= ST_MUL_SPT;
                    end
                end
                ST_MUL_SPT: begin
                    if (m2_fin) begin
                        lba_q  <= chs_lba;
                        bad_q  <= 1'b0;
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign done_o     = done_q;
    assign lba_o      = lba_q;
    assign bad_addr_o = bad_q;

endmodule

// File: rtl/sax_checker.sv
module sax_checker
    import sax_pkg::*;
#(
    parameter int MAX_LAT = 17
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         done_o,
    input logic         bad_addr_o,
    input logic [27:0]  lba_o,
    input xlate_state_e st,
    input logic         q_linear,
    input logic [7:0]   q_sec
);

    logic        pending;
    logic [15:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            lat_cnt <= '0;
        end else if (start_i && st == ST_IDLE) begin
            pending <= 1'b1;
            lat_cnt <= '0;
        end else if (done_o) begin
            pending <= 1'b0;
        end else if (pending) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_has_start_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> pending);

    assert_latency_bound_R9: assert property (@(posedge clk) disable iff (rst)
        pending |-> (lat_cnt <= 16'(MAX_LAT)));

    assert_linear_never_bad_R2: assert property (@(posedge clk) disable iff (rst)
        (done_o && q_linear) |-> !bad_addr_o);

    assert_sector_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !q_linear && q_sec == 8'd0) |-> bad_addr_o);

    assert_bad_clears_lba_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && bad_addr_o) |-> (lba_o == 28'd0));

    assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lba_o) || !$stable(bad_addr_o)) |-> done_o);

endmodule

bind sector_addr_xlate sax_checker #(
    .MAX_LAT(HEAD_CNT_W + SPT_W + 3)
) u_sax_checker (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .done_o    (done_o),
    .bad_addr_o(bad_addr_o),
    .lba_o     (lba_o),
    .st        (st),
    .q_linear  (q_addr.linear),
    .q_sec     (q_addr.sec)
);

// File: tb/test_sector_addr_xlate.sv
module test_sector_addr_xlate;

    localparam int CHS_LAT = 5 + 9 + 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  sec = '0, lo = '0, hi = '0, dh = '0;
    logic [15:0] g_cyl = 16'd1;
    logic [4:0]  g_head = 5'd1;
    logic [8:0]  g_spt = 9'd1;
    logic        done;
    logic [27:0] lba;
    logic        bad;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sector_addr_xlate i_sector_addr_xlate (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .sec_num_i  (sec),
        .cyl_lo_i   (lo),
        .cyl_hi_i   (hi),
        .dev_head_i (dh),
        .geo_cyls_i (g_cyl),
        .geo_heads_i(g_head),
        .geo_spt_i  (g_spt),
        .done_o     (done),
        .lba_o      (lba),
        .bad_addr_o (bad)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [28:0] model(input logic [7:0] s, l, h, d,
                                          input int c_n, h_n, s_n);
        longint cyl, hd, v;
        if (d[6]) return {1'b0, d[3:0], h, l, s};
        cyl = longint'({h, l});
        hd  = longint'(d[3:0]);
        if (cyl >= c_n || hd >= h_n || s == 8'd0 || int'(s) > s_n) return {1'b1, 28'd0};
        v = (cyl * h_n + hd) * s_n + longint'(s) - 1;
        return {1'b0, v[27:0]};
    endfunction

    task automatic scramble();
        sec = 8'($urandom); lo = 8'($urandom); hi = 8'($urandom); dh = 8'($urandom);
        g_cyl = 16'($urandom); g_head = 5'($urandom); g_spt = 9'($urandom);
    endtask

    task automatic run_one(input logic [7:0] s, l, h, d, input int c_n, h_n, s_n, input string req);
        logic [28:0] exp_v;
        int          exp_lat;
        int          lat;
        logic [27:0] lba_s;
        logic        bad_s;
        bit          held;
        exp_v   = model(s, l, h, d, c_n, h_n, s_n);
        exp_lat = (d[6] || exp_v[28]) ? 1 : CHS_LAT;
        @(negedge clk);
        sec = s; lo = l; hi = h; dh = d;
        g_cyl = 16'(c_n); g_head = 5'(h_n); g_spt = 9'(s_n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        scramble();   // R11: later input changes must not matter
        lat = 0;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        check(done && lat == exp_lat, {req, " R9 latency"}, lat, exp_lat);
        check(bad == exp_v[28], {req, " bad flag"}, bad, exp_v[28]);
        check(lba == exp_v[27:0], {req, " lba R11"}, lba, exp_v[27:0]);
        lba_s = lba; bad_s = bad; held = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (done || lba != lba_s || bad != bad_s) held = 1'b0;
        end
        check(held, {req, " R10 hold / R9 single done"}, lba, lba_s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c_n, h_n, s_n, cyl_v, hd_v, sec_v, pick;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !bad && lba == 28'd0, "R1 reset state", {done, bad, lba}, 0);

        // R2: linear form, no range check even with sector 0 and tiny geometry
        run_one(8'h00, 8'h34, 8'h12, 8'h4A, 1, 1, 1, "R2");
        run_one(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1, "R2");
        // R3: basic map, upper device/head bits ignored
        run_one(8'd5, 8'd10, 8'd0, 8'hB3, 100, 8, 32, "R3");
        // R4: cylinder bounds
        run_one(8'd1, 8'd99, 8'd0, 8'h00, 100, 4, 17, "R4");
        run_one(8'd1, 8'd100, 8'd0, 8'h00, 100, 4, 17, "R4");
        // R5: head bound
        run_one(8'd1, 8'd0, 8'd0, 8'h04, 100, 4, 17, "R5");
        run_one(8'd1, 8'd0, 8'd0, 8'h03, 100, 4, 17, "R5");
        // R6: sector zero
        run_one(8'd0, 8'd3, 8'd0, 8'h01, 100, 4, 17, "R6");
        // R7: sector bounds and full geometry
        run_one(8'd17, 8'd3, 8'd0, 8'h01, 100, 4, 17, "R7");
        run_one(8'd18, 8'd3, 8'd0, 8'h01, 100, 4, 17, "R7");
        run_one(8'd255, 8'hFE, 8'hFF, 8'h0F, 65535, 16, 256, "R7");
        run_one(8'd255, 8'd0, 8'd0, 8'h00, 10, 2, 255, "R7");
        // R8: invalid gives zero address
        run_one(8'd9, 8'd0, 8'd1, 8'h00, 256, 2, 8, "R8");

        // R9: start while running is ignored
        begin
            logic [28:0] exp_v;
            int          n_done;
            logic [27:0] first;
            exp_v = model(8'd7, 8'd20, 8'd0, 8'h02, 500, 6, 40);
            @(negedge clk);
            sec = 8'd7; lo = 8'd20; hi = 8'd0; dh = 8'h02;
            g_cyl = 16'd500; g_head = 5'd6; g_spt = 9'd40;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (4) @(negedge clk);
            dh = 8'h40; sec = 8'h55; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n_done = 0; first = '0;
            for (int k = 0; k < 45; k++) begin
                if (done) begin
                    if (n_done == 0) first = lba;
                    n_done++;
                end
                @(negedge clk);
            end
            check(n_done == 1, "R9 one done for busy restart", n_done, 1);
            check(first == exp_v[27:0], "R9 first result kept", first, exp_v[27:0]);
        end

        // Random stimulus biased to boundaries (R2..R8, R11)
        for (int t = 0; t < 250; t++) begin
            c_n = 1 + int'($urandom % 65535);
            h_n = 1 + int'($urandom % 16);
            s_n = 1 + int'($urandom % 256);
            pick = int'($urandom % 4);
            cyl_v = (pick == 0) ? c_n - 1 : (pick == 1) ? c_n :
                    (pick == 2) ? int'($urandom % c_n) : int'($urandom % 65536);
            if (cyl_v > 65535) cyl_v = 65535;
            pick = int'($urandom % 4);
            hd_v = (pick == 0) ? h_n - 1 : (pick == 1) ? h_n :
                   (pick == 2) ? int'($urandom % h_n) : int'($urandom % 16);
            if (hd_v > 15) hd_v = 15;
            pick = int'($urandom % 4);
            sec_v = (pick == 0) ? 0 : (pick == 1) ? s_n :
                    (pick == 2) ? s_n + 1 : 1 + int'($urandom % s_n);
            if (sec_v > 255) sec_v = 255;
            run_one(8'(sec_v), 8'(cyl_v), 8'(cyl_v >> 8),
                    {(($urandom % 4) == 0) ? 2'b11 : 2'b10, 2'($urandom), 4'(hd_v)},
                    c_n, h_n, s_n, "R3 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule